// File: doc/BRIEF.md
# Program Fetch Address Router

This block owns the 16-bit program counter of a small controller core and decides, for every fetch, which program store supplies the byte. A 64K-byte program space is split by an external-access strap: with the strap high, the bottom 4K bytes come from an on-chip ROM and every higher address is sent out on the external bus. With the strap low, every fetch goes external. The decision follows the counter itself. Stepping across the 4K boundary moves the next fetch to the bus with no extra cycle. The counter advances by one per fetch at the same rate whichever store is used.

The counter starts at the reset entry, address 0x0000. An interrupt acknowledge carrying a source number loads one of five fixed entry points, spaced eight bytes apart from 0x0003 upward. A branch strobe loads any 16-bit target. The outputs are a source select, a 12-bit ROM address, a 16-bit external address and the current counter value. The address output for the unused store is driven to zero, so that a consumer cannot latch a stray address.

Top module: `fetch_router`

## Requirements
- R1: While reset (rstN low) is asserted, and in the first cycle after it is released, pcValue is 0x0000.
- R2: With strapInternal = 1 and pcValue in 0x0000..0x0FFF, srcExternal = 0, romAddr = pcValue[11:0] and extAddr = 0.
- R3: With strapInternal = 1 and pcValue at 0x1000 or above, srcExternal = 1, extAddr = pcValue and romAddr = 0.
- R4: With strapInternal = 0, srcExternal = 1 and extAddr = pcValue for every counter value, including those below 0x1000.
- R5: When fetchStep is the only active request, pcValue rises by exactly one at the next clock edge, whichever store it is fetching from. 0xFFFF wraps to 0x0000.
- R6: With the strap high, one step from 0x0FFF gives pcValue 0x1000 and sets srcExternal in that same cycle.
- R7: irqAck with irqIndex n in 0..4 loads pcValue with 3 + 8·n at the next edge, so the vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R8: irqAck with irqIndex 5, 6 or 7 is ignored, and the branch and step requests are served as if no acknowledge were present.
- R9: Request priority is valid interrupt acknowledge over branchValid over fetchStep. The loser has no effect in that cycle.
- R10: branchValid loads pcValue with branchTarget at the next edge.
- R11: Reset overrides a concurrent interrupt acknowledge: the acknowledge has no effect while rstN is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| strapInternal | input | 1 | 1 = low 4K from internal ROM, 0 = everything external |
| fetchStep | input | 1 | Advance the counter after the current fetch |
| irqAck | input | 1 | Interrupt acknowledge, load a vector |
| irqIndex | input | 3 | Interrupt source number, 0..4 valid |
| branchValid | input | 1 | Load the counter with branchTarget |
| branchTarget | input | 16 | Branch destination |
| srcExternal | output | 1 | 1 = fetch from the external bus, 0 = internal ROM |
| romAddr | output | 12 | Internal ROM byte address, zero when external |
| extAddr | output | 16 | External fetch address, zero when internal |
| pcValue | output | 16 | Current program counter |

## Verification
The routing assertions assume that strapInternal is steady between clock edges. The step assertions assume that the request inputs are settled before each rising edge. The bench drives every input only just after a falling edge and changes the strap only while no load or step is pending. The bench model does not depend on the design's request ordering. It works out a single expected counter value from the priority rule and compares every output against it. It also compares the fetched byte against its own ROM and bus models.

// File: rtl/fetch_router_pkg.sv
package fetch_router_pkg;
  localparam int PC_W       = 16;
  localparam int ROM_AW     = 12;
  localparam int NUM_VEC    = 5;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;
  localparam int IDX_W      = 3;

  typedef struct packed {
    logic             takeVec;
    logic             takeBranch;
    logic             takeStep;
    logic [IDX_W-1:0] vecSel;
  } fetchStrobe_t;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_router_pkg::*;
#(
  parameter int NumVec = NUM_VEC,
  parameter int IdxW   = IDX_W
) (
  input  logic            irqAck,
  input  logic [IdxW-1:0] irqIndex,
  input  logic            branchValid,
  input  logic            fetchStep,
  output fetchStrobe_t    strobe
);
  localparam logic [IdxW-1:0] IdxLimit = IdxW'(NumVec);

  logic vecOk;

  always_comb begin
    vecOk = irqAck && (irqIndex < IdxLimit);
    strobe = '0;
    strobe.takeVec    = vecOk;
    strobe.takeBranch = !vecOk && branchValid;
    strobe.takeStep   = !vecOk && !branchValid && fetchStep;
    strobe.vecSel     = vecOk ? IDX_W'(irqIndex) : '0;
  end
endmodule

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_router_pkg::*;
#(
  parameter int PcW       = PC_W,
  parameter int RomAw     = ROM_AW,
  parameter int NumVec    = NUM_VEC,
  parameter int VecBase   = VEC_BASE,
  parameter int VecStride = VEC_STRIDE
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strapInternal,
  input  fetchStrobe_t     strobe,
  input  logic [PcW-1:0]   branchTarget,
  output logic [PcW-1:0]   pcValue,
  output logic             srcExternal,
  output logic [RomAw-1:0] romAddr,
  output logic [PcW-1:0]   extAddr
);
  localparam int HighW = PcW - RomAw;

  logic [PcW-1:0] vecTable [NumVec];
  logic [PcW-1:0] vecPick;
  logic [PcW-1:0] pcQ;
  logic [PcW-1:0] pcNext;
  logic           inLowWindow;

  for (genvar n = 0; n < NumVec; n++) begin : g_vec
    assign vecTable[n] = PcW'(VecBase + VecStride * n);
  end

  always_comb begin
    vecPick = '0;
    for (int n = 0; n < NumVec; n++) begin
      if (int'(strobe.vecSel) == n) vecPick = vecTable[n];
    end
  end

  always_comb begin
    pcNext = pcQ;
    if (strobe.takeVec)         pcNext = vecPick;
    else if (strobe.takeBranch) pcNext = branchTarget;
    else if (strobe.takeStep)   pcNext = pcQ + PcW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= pcNext;
  end

  always_comb begin
    inLowWindow = (pcQ[PcW-1:RomAw] == HighW'(0));
    srcExternal = !strapInternal || !inLowWindow;
    romAddr     = srcExternal ? '0 : pcQ[RomAw-1:0];
    extAddr     = srcExternal ? pcQ : '0;
    pcValue     = pcQ;
  end
endmodule

// File: rtl/fetch_router.sv
module fetch_router
  import fetch_router_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapInternal,
  input  logic              fetchStep,
  input  logic              irqAck,
  input  logic [IDX_W-1:0]  irqIndex,
  input  logic              branchValid,
  input  logic [PC_W-1:0]   branchTarget,
  output logic              srcExternal,
  output logic [ROM_AW-1:0] romAddr,
  output logic [PC_W-1:0]   extAddr,
  output logic [PC_W-1:0]   pcValue
);
  fetchStrobe_t strobe;

  fetch_ctrl #(.NumVec(NUM_VEC), .IdxW(IDX_W)) u_ctrl (
    .irqAck(irqAck), .irqIndex(irqIndex), .branchValid(branchValid),
    .fetchStep(fetchStep), .strobe(strobe)
  );

  fetch_dp #(.PcW(PC_W), .RomAw(ROM_AW), .NumVec(NUM_VEC),
             .VecBase(VEC_BASE), .VecStride(VEC_STRIDE)) u_dp (
    .clk(clk), .rstN(rstN), .strapInternal(strapInternal), .strobe(strobe),
    .branchTarget(branchTarget), .pcValue(pcValue), .srcExternal(srcExternal),
    .romAddr(romAddr), .extAddr(extAddr)
  );
endmodule

// File: rtl/fetch_router_chk.sv
module fetch_router_chk
  import fetch_router_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              strapInternal,
  input logic              fetchStep,
  input logic              irqAck,
  input logic [IDX_W-1:0]  irqIndex,
  input logic              branchValid,
  input logic [PC_W-1:0]   branchTarget,
  input logic              srcExternal,
  input logic [ROM_AW-1:0] romAddr,
  input logic [PC_W-1:0]   extAddr,
  input logic [PC_W-1:0]   pcValue
);
  localparam logic [PC_W-1:0] TopInternal = PC_W'((1 << ROM_AW) - 1);
  localparam logic [IDX_W-1:0] IdxLimit   = IDX_W'(NUM_VEC);

  logic ackOk;
  assign ackOk = irqAck && (irqIndex < IdxLimit);

  always_ff @(posedge clk) begin
    if (rstN === 1'b0) AST_RESET_ENTRY: assert (pcValue == '0); // R1
  end

  AST_ROUTE_INTERNAL: assert property (@(posedge clk) disable iff (!rstN)
    (strapInternal && pcValue <= TopInternal) |->
      (!srcExternal && romAddr == pcValue[ROM_AW-1:0] && extAddr == '0)); // R2

  AST_ROUTE_EXTERNAL: assert property (@(posedge clk) disable iff (!rstN)
    (strapInternal && pcValue > TopInternal) |->
      (srcExternal && extAddr == pcValue && romAddr == '0)); // R3

  AST_STRAP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !strapInternal |-> (srcExternal && extAddr == pcValue)); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStep && !ackOk && !branchValid) |=>
      pcValue == $past(pcValue) + PC_W'(1)); // R5

  AST_BOUNDARY_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    (strapInternal && $stable(strapInternal) && pcValue == TopInternal &&
     fetchStep && !ackOk && !branchValid) |=> (!strapInternal || srcExternal)); // R6

  AST_VECTOR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ackOk |=> pcValue == PC_W'(VEC_BASE + VEC_STRIDE * int'($past(irqIndex)))); // R7

  AST_BAD_INDEX_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !ackOk && !branchValid && !fetchStep) |=> $stable(pcValue)); // R8

  AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (branchValid && !ackOk) |=> pcValue == $past(branchTarget)); // R10
endmodule

bind fetch_router fetch_router_chk u_chk (
  .clk(clk), .rstN(rstN), .strapInternal(strapInternal), .fetchStep(fetchStep),
  .irqAck(irqAck), .irqIndex(irqIndex), .branchValid(branchValid),
  .branchTarget(branchTarget), .srcExternal(srcExternal), .romAddr(romAddr),
  .extAddr(extAddr), .pcValue(pcValue)
);

// File: tb/fetch_router_test.sv
module fetch_router_test;
  localparam int RomDepth = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapInternal = 1'b1;
  logic        fetchStep = 1'b0;
  logic        irqAck = 1'b0;
  logic [2:0]  irqIndex = '0;
  logic        branchValid = 1'b0;
  logic [15:0] branchTarget = '0;
  logic        srcExternal;
  logic [11:0] romAddr;
  logic [15:0] extAddr;
  logic [15:0] pcValue;

  int total = 0;
  int bad = 0;
  logic [15:0] expPc = '0;
  logic [7:0]  romArr [RomDepth];

  always #2 clk = ~clk;

  fetch_router uut (.*);

  function automatic logic [7:0] romByte(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]};
  endfunction

  function automatic logic [7:0] busByte(input logic [15:0] a);
    return a[15:8] + a[7:0] + 8'h5A;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idleInputs();
    fetchStep = 1'b0; irqAck = 1'b0; irqIndex = '0;
    branchValid = 1'b0; branchTarget = '0;
  endtask

  task automatic checkAll(input string pcTag);
    bit expExt;
    string rTag;
    logic [7:0] gotByte, wantByte;
    expExt = !strapInternal || (expPc >= 16'h1000);
    rTag = !strapInternal ? "R4" : (expExt ? "R3" : "R2");
    total++;
    if (pcValue !== expPc) begin
      bad++;
      $display("FAIL %s pcValue actual=%h expected=%h", pcTag, pcValue, expPc);
    end
    total++;
    if (srcExternal !== expExt || romAddr !== (expExt ? 12'h0 : expPc[11:0]) ||
        extAddr !== (expExt ? expPc : 16'h0)) begin
      bad++;
      $display("FAIL %s route actual=%b/%h/%h expected=%b/%h/%h", rTag,
               srcExternal, romAddr, extAddr, expExt,
               expExt ? 12'h0 : expPc[11:0], expExt ? expPc : 16'h0);
    end
    gotByte  = srcExternal ? busByte(extAddr) : romArr[romAddr];
    wantByte = expExt ? busByte(expPc) : romByte(expPc[11:0]);
    total++;
    if (gotByte !== wantByte) begin
      bad++;
      $display("FAIL %s fetched byte actual=%h expected=%h", rTag, gotByte, wantByte);
    end
  endtask

  task automatic doBranch(input logic [15:0] t);
    @(negedge clk);
    idleInputs(); branchValid = 1'b1; branchTarget = t;
    tick(); expPc = t;
    @(negedge clk); idleInputs();
    checkAll("R10");
  endtask

  task automatic doStep(input string tag);
    @(negedge clk);
    idleInputs(); fetchStep = 1'b1;
    tick(); expPc = expPc + 16'd1;
    @(negedge clk); idleInputs();
    checkAll(tag);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < RomDepth; a++) romArr[a] = romByte(12'(a));

    // R1, R11: reset with a pending acknowledge
    irqAck = 1'b1; irqIndex = 3'd2;
    tick(); tick();
    @(negedge clk);
    expPc = 16'h0000;
    checkAll("R11");
    idleInputs();
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R2, R3, R5, R6: full internal window sweep plus boundary
    for (int i = 0; i < 4100; i++) doStep(expPc == 16'h0FFF ? "R6" : "R5");

    // R4: strap low, low addresses go external, step rate unchanged
    @(negedge clk); strapInternal = 1'b0;
    doBranch(16'h0000);
    for (int i = 0; i < 300; i++) doStep("R5");
    doBranch(16'h0FFE);
    doStep("R4"); doStep("R4"); doStep("R4");
    @(negedge clk); strapInternal = 1'b1;
    @(negedge clk); checkAll("R3");

    // R5: wrap at the top of the space
    doBranch(16'hFFFE);
    doStep("R5"); doStep("R5"); doStep("R5");

    // R7, R8: all indices
    for (int n = 0; n < 8; n++) begin
      doBranch(16'h2345);
      @(negedge clk);
      idleInputs(); irqAck = 1'b1; irqIndex = 3'(n);
      tick();
      if (n < 5) expPc = 16'(3 + 8 * n);
      @(negedge clk); idleInputs();
      checkAll(n < 5 ? "R7" : "R8");
    end

    // R8: bad index with branch and with step still served
    doBranch(16'h0100);
    @(negedge clk);
    idleInputs(); irqAck = 1'b1; irqIndex = 3'd6; fetchStep = 1'b1;
    tick(); expPc = 16'h0101;
    @(negedge clk); idleInputs(); checkAll("R8");
    @(negedge clk);
    irqAck = 1'b1; irqIndex = 3'd7; branchValid = 1'b1; branchTarget = 16'h8000;
    tick(); expPc = 16'h8000;
    @(negedge clk); idleInputs(); checkAll("R8");

    // R9: priority orderings
    @(negedge clk);
    irqAck = 1'b1; irqIndex = 3'd4; branchValid = 1'b1;
    branchTarget = 16'h7777; fetchStep = 1'b1;
    tick(); expPc = 16'h0023;
    @(negedge clk); idleInputs(); checkAll("R9");
    @(negedge clk);
    branchValid = 1'b1; branchTarget = 16'h0FFF; fetchStep = 1'b1;
    tick(); expPc = 16'h0FFF;
    @(negedge clk); idleInputs(); checkAll("R9");

    // R11: reset asserted again with acknowledge pending
    @(negedge clk);
    rstN = 1'b0; irqAck = 1'b1; irqIndex = 3'd1;
    tick(); tick();
    @(negedge clk); expPc = 16'h0000; checkAll("R11");
    idleInputs(); rstN = 1'b1;
    @(negedge clk); checkAll("R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule